// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block sits between a host processor and a power-management microcontroller. The host uses a small 32-bit register window. It loads the source and destination pointers and up to four outbound data words, then writes a command word. That write raises a one-cycle doorbell toward the controller, and the doorbell carries the latched command word. The status word reports the command as busy until the controller answers.

The controller reads the pointers and the outbound words through its own ports. It loads up to four response words into the inbound buffer, then pulses a completion strobe together with an error flag and an 8-bit error code. The busy bit then falls and the error bit and code are posted into the status word.

When the command asked for an interrupt, a pending flag is set and drives the interrupt output until the host clears it. A command written while the previous one is still busy is dropped, and a sticky flag records that this happened.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every host-readable location (command 0x00, status 0x04, pointers 0x08/0x0C, outbound words 0x80-0x8C, inbound words 0x90-0x9C) reads zero, and irq and db_pulse are low.
- R2: A host write to 0x00 while not busy latches the word, sets status bit 0 (busy), and clears status bit 1 (error) and the code in bits 23:16. In the cycle after the write edge, db_pulse is high for exactly one cycle and db_cmd carries the written word unchanged. In that word, bits 7:0 are the command code, bits 15:12 the subcommand and bits 20:16 the payload length in bytes.
- R3: A done pulse while busy clears busy and copies done_err into status bit 1. When done_err is 1, status bits 23:16 take done_code; otherwise they become zero.
- R4: On completion, status bit 2 (interrupt pending) is set only if bit 8 of the latched command was 1. irq equals the pending flag, so irq stays low for a command that polls.
- R5: A host write to 0x04 clears the pending flag when bit 2 of the written data is 1. The same write leaves busy and error unchanged.
- R6: A host write to 0x00 while busy is ignored: the latched command does not change and no doorbell is raised. The write sets a sticky overrun flag at status bit 3, which a status write with bit 3 set clears.
- R7: The source pointer (0x08), the destination pointer (0x0C) and the outbound words (0x80 + 4*i) are host read/write. The pointers drive src_ptr and dst_ptr, and ob_data returns outbound word ob_idx in the same cycle.
- R8: Inbound word i (0x90 + 4*i) is loaded by rsp_we with rsp_idx = i. Host writes to the inbound addresses have no effect.
- R9: With h_byte = 1, a read returns the byte selected by h_addr[1:0] (0 = least significant) of the addressed word, zero-extended.
- R10: A done pulse while not busy changes neither the status word nor irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | AW | Host byte address |
| h_we | input | 1 | Host write strobe |
| h_byte | input | 1 | Host byte-read select |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data (combinational) |
| db_pulse | output | 1 | Doorbell to controller, one cycle per accepted command |
| db_cmd | output | 32 | Latched command word |
| src_ptr | output | 32 | Source pointer register |
| dst_ptr | output | 32 | Destination pointer register |
| ob_idx | input | 2 | Controller outbound word index |
| ob_data | output | 32 | Outbound word at ob_idx |
| rsp_we | input | 1 | Controller response word write |
| rsp_idx | input | 2 | Response word index |
| rsp_data | input | 32 | Response word |
| done | input | 1 | Controller completion strobe |
| done_err | input | 1 | Completion carries an error |
| done_code | input | CW | Error code for the status word |
| irq | output | 1 | Completion interrupt |

## Verification
The bench runs one command that polls and one that requests an interrupt and ends in error. A design that ignored bit 8 would assert irq on the polled command, and a design that did not clear the code on the next command would still show the old code in status bits 23:16.

It writes the status register with all low bits set, checking that only the pending flag clears and that busy or error are not wiped. It issues a second command while busy, to catch a design that relatches the command or re-rings the doorbell.

A completion pulse with nothing outstanding checks that the controller cannot post stray status. Host writes into the inbound buffer and byte reads at different lanes catch a buffer that is writable from the host or that selects the wrong byte lane.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] h_addr,
  input  logic          h_we,
  input  logic          h_byte,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  output logic          db_pulse,
  output logic [31:0]   db_cmd,
  output logic [31:0]   src_ptr,
  output logic [31:0]   dst_ptr,
  input  logic [1:0]    ob_idx,
  output logic [31:0]   ob_data,
  input  logic          rsp_we,
  input  logic [1:0]    rsp_idx,
  input  logic [31:0]   rsp_data,
  input  logic          done,
  input  logic          done_err,
  input  logic [CW-1:0] done_code,
  output logic          irq
);
  localparam int NW = 4;
  localparam logic [AW-1:0] A_CMD  = AW'(8'h00);
  localparam logic [AW-1:0] A_STS  = AW'(8'h04);
  localparam logic [AW-1:0] A_SRC  = AW'(8'h08);
  localparam logic [AW-1:0] A_DST  = AW'(8'h0C);
  localparam logic [AW-1:0] A_OUTB = AW'(8'h80);
  localparam logic [AW-1:0] A_INB  = AW'(8'h90);
  localparam int IRQ_BIT = 8;

  logic [31:0]   cmd_q, src_q, dst_q;
  logic [31:0]   ob_q [NW];
  logic [31:0]   ib_q [NW];
  logic          busy, err, pend, ovr, db_q;
  logic [CW-1:0] code_q;

  wire       in_outb = h_addr[AW-1:4] == A_OUTB[AW-1:4];
  wire       in_inb  = h_addr[AW-1:4] == A_INB[AW-1:4];
  wire [1:0] widx    = h_addr[3:2];
  wire       wr_cmd  = h_we && (h_addr == A_CMD);
  wire       wr_sts  = h_we && (h_addr == A_STS);
  wire       accept  = wr_cmd && !busy;
  wire       finish  = done && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      busy   <= 1'b0;
      err    <= 1'b0;
      pend   <= 1'b0;
      ovr    <= 1'b0;
      db_q   <= 1'b0;
      code_q <= '0;
      for (int i = 0; i < NW; i++) begin
        ob_q[i] <= '0;
        ib_q[i] <= '0;
      end
    end else begin
      db_q <= accept;
      if (accept) begin
        cmd_q  <= h_wdata;
        busy   <= 1'b1;
        err    <= 1'b0;
        code_q <= '0;
      end else if (finish) begin
        busy   <= 1'b0;
        err    <= done_err;
        code_q <= done_err ? done_code : '0;
      end
      if (wr_cmd && busy)
        ovr <= 1'b1;
      else if (wr_sts && h_wdata[3])
        ovr <= 1'b0;
      if (finish && cmd_q[IRQ_BIT])
        pend <= 1'b1;
      else if (wr_sts && h_wdata[2])
        pend <= 1'b0;
      if (h_we && h_addr == A_SRC) src_q <= h_wdata;
      if (h_we && h_addr == A_DST) dst_q <= h_wdata;
      for (int i = 0; i < NW; i++) begin
        if (h_we && in_outb && widx == 2'(i)) ob_q[i] <= h_wdata;
        if (rsp_we && rsp_idx == 2'(i))      ib_q[i] <= rsp_data;
      end
    end
  end

  logic [31:0] sts, word;
  always_comb begin
    sts = '0;
    sts[3:0] = {ovr, pend, err, busy};
    sts[16 +: CW] = code_q;
    word = '0;
    if (in_outb)             word = ob_q[widx];
    else if (in_inb)         word = ib_q[widx];
    else if (h_addr == A_CMD) word = cmd_q;
    else if (h_addr == A_STS) word = sts;
    else if (h_addr == A_SRC) word = src_q;
    else if (h_addr == A_DST) word = dst_q;
  end

  wire [31:0] lane = word >> {h_addr[1:0], 3'b000};
  assign h_rdata  = h_byte ? {24'h0, lane[7:0]} : word;
  assign db_pulse = db_q;
  assign db_cmd   = cmd_q;
  assign src_ptr  = src_q;
  assign dst_ptr  = dst_q;
  assign ob_data  = ob_q[ob_idx];
  assign irq      = pend;

  assert_doorbell_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    db_pulse |=> !db_pulse);
  assert_busy_rings_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> db_pulse);
  assert_done_clears_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy) |=> !busy);
  assert_irq_needs_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cmd_q[IRQ_BIT]));
  assert_w1c_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && h_wdata[2] && !(done && busy)) |=> !irq);
  assert_busy_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && busy && !done) |=> (busy && !db_pulse && $stable(db_cmd)));
  assert_stray_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !busy && !wr_cmd) |=> ($stable(err) && $stable(code_q) && !busy));
endmodule

// File: tb/ipc_mailbox_bench.sv
module ipc_mailbox_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  h_addr = '0;
  logic        h_we = 1'b0, h_byte = 1'b0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata, db_cmd, src_ptr, dst_ptr, ob_data;
  logic        db_pulse, irq;
  logic [1:0]  ob_idx = '0, rsp_idx = '0;
  logic        rsp_we = 1'b0, done = 1'b0, done_err = 1'b0;
  logic [31:0] rsp_data = '0;
  logic [7:0]  done_code = '0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ipc_mailbox u_ipc_mailbox (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_we(h_we), .h_byte(h_byte),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .db_pulse(db_pulse), .db_cmd(db_cmd),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .ob_idx(ob_idx), .ob_data(ob_data),
    .rsp_we(rsp_we), .rsp_idx(rsp_idx), .rsp_data(rsp_data), .done(done),
    .done_err(done_err), .done_code(done_code), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    h_addr = a; h_wdata = d; h_we = 1'b1;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic hread(logic [7:0] a, logic by, string req, logic [31:0] exp);
    @(negedge clk);
    h_addr = a; h_byte = by;
    #1;
    chk(req, h_rdata, exp);
    h_byte = 1'b0;
  endtask

  task automatic complete(logic e, logic [7:0] c);
    @(negedge clk);
    done = 1'b1; done_err = e; done_code = c;
    @(negedge clk);
    done = 1'b0; done_err = 1'b0; done_code = '0;
  endtask

  task automatic respond(logic [1:0] i, logic [31:0] d);
    @(negedge clk);
    rsp_we = 1'b1; rsp_idx = i; rsp_data = d;
    @(negedge clk);
    rsp_we = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 16; a += 4) hread(8'(a), 1'b0, "R1", 32'h0);
    for (int a = 8'h80; a < 8'hA0; a += 4) hread(8'(a), 1'b0, "R1", 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 doorbell", {31'h0, db_pulse}, 32'h0);
  endtask

  task automatic t_pointers;
    hwrite(8'h08, 32'h1000_2000);
    hwrite(8'h0C, 32'h3000_4000);
    for (int i = 0; i < 4; i++) hwrite(8'(8'h80 + 4 * i), 32'hC0DE_0000 + 32'(i));
    hread(8'h08, 1'b0, "R7 src", 32'h1000_2000);
    hread(8'h0C, 1'b0, "R7 dst", 32'h3000_4000);
    hread(8'h88, 1'b0, "R7 outbound", 32'hC0DE_0002);
    chk("R7 src_ptr", src_ptr, 32'h1000_2000);
    chk("R7 dst_ptr", dst_ptr, 32'h3000_4000);
    for (int i = 0; i < 4; i++) begin
      ob_idx = 2'(i); #1;
      chk("R7 ob_data", ob_data, 32'hC0DE_0000 + 32'(i));
    end
  endtask

  task automatic t_poll_cmd;
    @(negedge clk);
    h_addr = 8'h00; h_wdata = 32'h0004_3025; h_we = 1'b1;
    @(posedge clk); #1;
    chk("R2 doorbell", {31'h0, db_pulse}, 32'h1);
    chk("R2 db_cmd", db_cmd, 32'h0004_3025);
    @(negedge clk);
    h_we = 1'b0;
    @(posedge clk); #1;
    chk("R2 doorbell single", {31'h0, db_pulse}, 32'h0);
    hread(8'h04, 1'b0, "R2 busy", 32'h0000_0001);
    respond(2'd0, 32'h1111_2222);
    respond(2'd1, 32'hA1B2_C3D4);
    complete(1'b0, 8'h00);
    hread(8'h04, 1'b0, "R3 ok status", 32'h0);
    chk("R4 no irq when polled", {31'h0, irq}, 32'h0);
    hread(8'h90, 1'b0, "R8 inbound0", 32'h1111_2222);
    hread(8'h94, 1'b0, "R8 inbound1", 32'hA1B2_C3D4);
    hread(8'h96, 1'b1, "R9 byte2", 32'h0000_00B2);
    hread(8'h97, 1'b1, "R9 byte3", 32'h0000_00A1);
    hread(8'h94, 1'b1, "R9 byte0", 32'h0000_00D4);
  endtask

  task automatic t_irq_err;
    hwrite(8'h00, 32'h0000_0111);
    chk("R4 irq low while busy", {31'h0, irq}, 32'h0);
    complete(1'b1, 8'h06);
    hread(8'h04, 1'b0, "R3 error status", 32'h0006_0006);
    chk("R4 irq", {31'h0, irq}, 32'h1);
    hwrite(8'h04, 32'h0000_0007);
    hread(8'h04, 1'b0, "R5 w1c keeps error", 32'h0006_0002);
    chk("R5 irq cleared", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_overrun;
    hwrite(8'h00, 32'h0000_0042);
    hread(8'h04, 1'b0, "R2 clears code", 32'h0000_0001);
    @(negedge clk);
    h_addr = 8'h00; h_wdata = 32'h0000_0199; h_we = 1'b1;
    @(posedge clk); #1;
    chk("R6 no doorbell", {31'h0, db_pulse}, 32'h0);
    @(negedge clk);
    h_we = 1'b0;
    hread(8'h00, 1'b0, "R6 command kept", 32'h0000_0042);
    hread(8'h04, 1'b0, "R6 overrun", 32'h0000_0009);
    complete(1'b0, 8'h00);
    hread(8'h04, 1'b0, "R6 sticky", 32'h0000_0008);
    chk("R6 no irq", {31'h0, irq}, 32'h0);
    hwrite(8'h04, 32'h0000_0008);
    hread(8'h04, 1'b0, "R6 cleared", 32'h0);
  endtask

  task automatic t_stray;
    complete(1'b1, 8'h05);
    hread(8'h04, 1'b0, "R10 stray done", 32'h0);
    chk("R10 irq", {31'h0, irq}, 32'h0);
    hwrite(8'h90, 32'hDEAD_BEEF);
    hread(8'h90, 1'b0, "R8 host write ignored", 32'h1111_2222);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pointers();
    t_poll_cmd();
    t_irq_err();
    t_overrun();
    t_stray();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule